// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Code Select

This block samples four shared frequency-select pins and one shared mode pin while the power-on reset is held. It keeps those levels in an internal strap store and then hands the pins over to the clock output drivers. The strap store is updated at every clock edge while the reset is held. The last edge before reset is released decides the stored value. Later pin activity has no effect until the next power-on reset.

From the stored straps and a software control word, the block builds the active 5-bit frequency code. When the override bit is clear, the code is the four stored straps with a zero above them. When the override bit is set, the code is the value software wrote. The code sits in a register, so it changes only on a clock edge. The block also tells the rest of the chip whether the shared mode-controlled pin is a bus-clock stop input or a reference clock output. It offers an inverted copy of the straps for the register readback path.

Top module: `strap_select_top`

## Requirements
- R1: While `por_n` is low at a clock edge, the next cycle shows `pin_oe` = 0, `freq_code` = 0 and the override cleared.
- R2: Each clock edge with `por_n` low captures `fs_pin_in` and `mode_pin_in`. The value held after release is the one from the last edge with `por_n` low.
- R3: After release, changes on `fs_pin_in` and `mode_pin_in` leave `fs_readback_n`, `stop_in_sel` and `freq_code` unchanged.
- R4: From the first clock edge with `por_n` high, every bit of `pin_oe` is 1. Bits [3:0] belong to the frequency-select pins and bit [4] to the mode pin.
- R5: With the override clear, `freq_code` is {1'b0, fs[3:0]}, built from the stored straps. It becomes valid at the first edge after release.
- R6: An edge with `por_n` high, `cfg_wr` = 1 and `cfg_sel` = 1 makes `freq_code` equal to `cfg_code` in the next cycle. Bit 4 of the code is the extra software-only select bit.
- R7: An edge with `por_n` high, `cfg_wr` = 1 and `cfg_sel` = 0 returns `freq_code` to the strap code in the next cycle.
- R8: `fs_readback_n` is the bitwise inverse of the stored frequency straps.
- R9: `stop_in_sel` is the inverse of the stored mode strap. A value of 1 means the shared pin acts as the bus-clock stop input, and 0 means it drives a reference clock.
- R10: `cfg_sel` and `cfg_code` have no effect without `cfg_wr`, and a write during power-on reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| fs_pin_in | input | 4 | Levels on the shared frequency-select pins |
| mode_pin_in | input | 1 | Level on the shared mode pin |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_sel | input | 1 | Override bit: 0 uses the straps, 1 uses the software code |
| cfg_code | input | 5 | Software frequency code |
| pin_oe | output | 5 | Output enables of the shared pins |
| freq_code | output | 5 | Active frequency code, registered |
| fs_readback_n | output | 4 | Inverted stored straps for readback |
| stop_in_sel | output | 1 | 1 = shared pin is the stop input |

## Verification
A strap store that kept tracking the pins after release would show up on `fs_readback_n` one cycle after any pin change. In strap mode it would also show up on `freq_code`. An override bit that was lost or left stuck would give a wrong `freq_code` on the cycle right after a write. A write accepted during reset would leave the software code on `freq_code` at the first cycle after release. Output enables that rose late or early would differ from the expected value at the release edge. Every fault in this block is therefore visible at the ports within one cycle of its cause.

// File: rtl/strap_pkg.sv
// Shared widths and helpers for the strap capture block.
// Assumes the frequency code is one software-only bit above the strap bits.
package strap_pkg;
    localparam int unsigned FS_W   = 4;
    localparam int unsigned CODE_W = FS_W + 1;
    localparam int unsigned PIN_N  = FS_W + 1;

    typedef logic [FS_W-1:0]   fs_t;
    typedef logic [CODE_W-1:0] code_t;

    // Extend a strap word to a full code with the software-only bit clear.
    function automatic code_t strap_to_code(input fs_t fs);
        return {{(CODE_W-FS_W){1'b0}}, fs};
    endfunction
endpackage

// File: rtl/strap_capture.sv
// Samples the shared pins during power-on reset and holds them afterwards.
// Assumes por_n is synchronous to clk. The pins are sampled at every edge while por_n is low.
module strap_capture #(
    parameter int unsigned FS_W = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [FS_W-1:0]   fs_pin_in,
    input  logic              mode_pin_in,
    output logic [FS_W-1:0]   fs_held,
    output logic              mode_held,
    output logic [FS_W:0]     pin_oe,
    output logic [FS_W-1:0]   fs_readback_n
);
    localparam int unsigned PINS = FS_W + 1;

    // Track the pins while reset is held, then freeze.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            fs_held   <= fs_pin_in;
            mode_held <= mode_pin_in;
        end
    end

    // Hand each pin to its output driver once reset is released.
    for (genvar p = 0; p < PINS; p++) begin : g_oe
        always_ff @(posedge clk) begin
            pin_oe[p] <= por_n;
        end
    end

    // Readback copy carries each strap inverted.
    for (genvar b = 0; b < FS_W; b++) begin : g_rb
        assign fs_readback_n[b] = ~fs_held[b];
    end
endmodule

// File: rtl/code_select.sv
// Holds the software override word and registers the active frequency code.
// Assumes the write strobe is a single-cycle pulse in the clk domain.
module code_select #(
    parameter int unsigned FS_W   = 4,
    parameter int unsigned CODE_W = FS_W + 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [FS_W-1:0]   fs_held,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [CODE_W-1:0] cfg_code,
    output logic [CODE_W-1:0] freq_code
);
    logic              sel_q;
    logic [CODE_W-1:0] sw_q;
    logic              sel_nx;
    logic [CODE_W-1:0] sw_nx;
    logic [CODE_W-1:0] strap_code;

    assign strap_code = {{(CODE_W-FS_W){1'b0}}, fs_held};

    // Next override state: a write replaces the stored value.
    always_comb begin
        sel_nx = cfg_wr ? cfg_sel  : sel_q;
        sw_nx  = cfg_wr ? cfg_code : sw_q;
    end

    // Store the override word; reset selects the straps.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            sel_q <= 1'b0;
            sw_q  <= '0;
        end else begin
            sel_q <= sel_nx;
            sw_q  <= sw_nx;
        end
    end

    // Register the chosen code so it moves only on an edge.
    always_ff @(posedge clk) begin
        if (!por_n) freq_code <= '0;
        else        freq_code <= sel_nx ? sw_nx : strap_code;
    end
endmodule

// File: rtl/strap_select_top.sv
// Top of the power-on strap capture and frequency code select block.
// Assumes one clock domain and a synchronous active-low power-on reset.
module strap_select_top #(
    parameter int unsigned FS_W   = 4,
    parameter int unsigned CODE_W = FS_W + 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [FS_W-1:0]   fs_pin_in,
    input  logic              mode_pin_in,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [CODE_W-1:0] cfg_code,
    output logic [FS_W:0]     pin_oe,
    output logic [CODE_W-1:0] freq_code,
    output logic [FS_W-1:0]   fs_readback_n,
    output logic              stop_in_sel
);
    logic [FS_W-1:0] fs_held;
    logic            mode_held;

    strap_capture #(.FS_W(FS_W)) u_cap (
        .clk           (clk),
        .por_n         (por_n),
        .fs_pin_in     (fs_pin_in),
        .mode_pin_in   (mode_pin_in),
        .fs_held       (fs_held),
        .mode_held     (mode_held),
        .pin_oe        (pin_oe),
        .fs_readback_n (fs_readback_n)
    );

    code_select #(.FS_W(FS_W), .CODE_W(CODE_W)) u_sel (
        .clk       (clk),
        .por_n     (por_n),
        .fs_held   (fs_held),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_code  (cfg_code),
        .freq_code (freq_code)
    );

    // Low mode strap turns the shared pin into the stop input.
    assign stop_in_sel = ~mode_held;
endmodule

// File: rtl/strap_select_checks.sv
// Port-level temporal checks for strap_select_top, attached by bind.
// Assumes por_n is driven low from time zero.
module strap_select_checks #(
    parameter int unsigned FS_W   = 4,
    parameter int unsigned CODE_W = FS_W + 1
) (
    input logic              clk,
    input logic              por_n,
    input logic [FS_W-1:0]   fs_pin_in,
    input logic              mode_pin_in,
    input logic              cfg_wr,
    input logic              cfg_sel,
    input logic [CODE_W-1:0] cfg_code,
    input logic [FS_W:0]     pin_oe,
    input logic [CODE_W-1:0] freq_code,
    input logic [FS_W-1:0]   fs_readback_n,
    input logic              stop_in_sel
);
    // R1: reset drops every output enable and the code
    a_r1_reset_state: assert property (@(posedge clk)
        !por_n |=> (pin_oe == '0 && freq_code == '0));

    // R2 / R8: captured straps read back inverted
    a_r2_capture_inverted: assert property (@(posedge clk)
        !por_n |=> fs_readback_n == ~$past(fs_pin_in));

    // R9: mode strap decides the stop-input role
    a_r9_stop_role: assert property (@(posedge clk)
        !por_n |=> stop_in_sel == !$past(mode_pin_in));

    // R3: held straps frozen after release
    a_r3_frozen: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) |-> ($stable(fs_readback_n) && $stable(stop_in_sel)));

    // R4: enables all high once released
    a_r4_oe_on: assert property (@(posedge clk) disable iff (!por_n)
        por_n |=> &pin_oe);

    // R6: override write lands next cycle
    a_r6_override: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_wr && cfg_sel) |=> freq_code == $past(cfg_code));

    // R7: strap select write returns to the strap code
    a_r7_strap_back: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_wr && !cfg_sel) |=> freq_code == {1'b0, ~fs_readback_n});
endmodule

bind strap_select_top strap_select_checks #(.FS_W(FS_W), .CODE_W(CODE_W)) u_checks (.*);

// File: tb/tb_strap_select_top.sv
// Scoreboard bench: the driver pushes expected port states and the monitor pops and compares them.
module tb_strap_select_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [3:0] fs_pin_in = 4'h0;
    logic       mode_pin_in = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [4:0] cfg_code = 5'h0;
    logic [4:0] pin_oe;
    logic [4:0] freq_code;
    logic [3:0] fs_readback_n;
    logic       stop_in_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string      tag;
        logic [4:0] oe;
        logic [4:0] code;
        logic [3:0] rb;
        logic       stp;
    } exp_t;
    exp_t q[$];

    // Reference state derived from the requirements
    logic [3:0] m_fs = 4'h0;
    logic       m_mode = 1'b0;
    logic       m_sel = 1'b0;
    logic [4:0] m_sw = 5'h0;

    always #2.5 clk = ~clk;

    strap_select_top dut (
        .clk(clk), .por_n(por_n), .fs_pin_in(fs_pin_in), .mode_pin_in(mode_pin_in),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_code(cfg_code),
        .pin_oe(pin_oe), .freq_code(freq_code), .fs_readback_n(fs_readback_n),
        .stop_in_sel(stop_in_sel)
    );

    task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "pin_oe", {3'b0, pin_oe}, {3'b0, e.oe});
            cmp(e.tag, "freq_code", {3'b0, freq_code}, {3'b0, e.code});
            cmp(e.tag, "fs_readback_n", {4'b0, fs_readback_n}, {4'b0, e.rb});
            cmp(e.tag, "stop_in_sel", {7'b0, stop_in_sel}, {7'b0, e.stp});
        end
    end

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic step(string tag, logic por, logic [3:0] pins, logic md,
                        logic wr, logic sel, logic [4:0] code);
        exp_t e;
        @(negedge clk);
        por_n = por; fs_pin_in = pins; mode_pin_in = md;
        cfg_wr = wr; cfg_sel = sel; cfg_code = code;
        @(posedge clk);
        if (!por) begin
            m_fs = pins; m_mode = md; m_sel = 1'b0; m_sw = 5'h0;
            e.oe = 5'h00; e.code = 5'h00;
        end else begin
            if (wr) begin m_sel = sel; m_sw = code; end
            e.oe = 5'h1F;
            e.code = m_sel ? m_sw : {1'b0, m_fs};
        end
        e.tag = tag; e.rb = ~m_fs; e.stp = ~m_mode;
        q.push_back(e);
    endtask

    initial begin
        // R1 reset state, R2 last sample wins
        step("R1", 0, 4'b1010, 1, 0, 0, 5'h00);
        step("R1", 0, 4'b1010, 1, 0, 0, 5'h00);
        step("R2", 0, 4'b0110, 0, 0, 0, 5'h00);
        // R4 R5 R8 R9 release
        step("R4_R5_R8_R9", 1, 4'b0110, 0, 0, 0, 5'h00);
        // R3 pin activity ignored
        step("R3", 1, 4'b1001, 1, 0, 0, 5'h00);
        step("R3", 1, 4'b1111, 1, 0, 0, 5'h00);
        // R6 override
        step("R6", 1, 4'b0000, 0, 1, 1, 5'b10011);
        // R10 inputs without strobe
        step("R10", 1, 4'b0000, 0, 0, 0, 5'b00001);
        // R7 back to straps
        step("R7", 1, 4'b0000, 0, 1, 0, 5'b11100);
        // R6 all-ones code
        step("R6", 1, 4'b0000, 0, 1, 1, 5'b11111);
        step("R10", 1, 4'b0000, 0, 0, 0, 5'b00000);
        // R10 write during reset discarded, R1 again
        step("R1", 0, 4'b1111, 1, 1, 1, 5'b10101);
        step("R10", 0, 4'b1111, 1, 1, 1, 5'b10101);
        step("R10_R5", 1, 4'b0000, 0, 0, 0, 5'h00);
        step("R9", 1, 4'b0101, 0, 0, 0, 5'h00);
        // R2 all-zero straps
        step("R2", 0, 4'b0000, 0, 0, 0, 5'h00);
        step("R5", 1, 4'b1111, 1, 0, 0, 5'h00);
        step("R7", 1, 4'b1111, 1, 1, 0, 5'h1F);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule